// File: doc/BRIEF.md
# Byte-Wide Flash Program/Erase Sequencer

This block is the on-die automation of a byte-wide parallel flash memory, built as a synchronous model. A host drives asynchronous active-low chip-select, read-strobe and write-strobe lines with an address and a byte. The block brings these lines into its clock domain. It captures command writes and decodes two-write setup/execute sequences. It then runs self-timed algorithms for byte programming, chip erase and multi-block erase. Each algorithm issues timed pulses, verifies after every pulse and bounds its retries. An erase first programs every byte of its region to 0x00, verifying each byte, and only then pulses the region back to 0xFF.

The array is a behavioural store whose cells follow flash physics. A program pulse can only clear bits, so the stored byte becomes old AND new. An erase pulse sets the whole region to 0xFF. A two-bit fault input blocks program pulses, erase pulses, or both, which lets stuck cells be modelled. While an algorithm runs, a read returns a status byte instead of array data. A failed algorithm leaves the block in a status state until the host writes a reset command.

The address space holds 2^ADDR_W bytes. With ADDR_W = 18 this is 256K x 8. The top eighth is divided into eight small blocks, numbered 14 to 21 upward. The rest is fourteen large blocks, each four times the size of a small block, numbered 0 to 13 from address zero. At ADDR_W = 18 the small blocks are 4 KB, starting at 0x38000, and the large blocks are 16 KB.

Top module: `flash_auto_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF and the block is in array-read mode: a read at an address returns the stored byte on dout with dout_oe high.
- R2: A write cycle spans the time both ce_n and we_n are low. The address is taken when the later of the two falls, and the data when the earlier of the two rises. Writes may be controlled by either strobe.
- R3: Writing 0x40 and then a second write (address A, byte D) programs A. On success the byte at A reads old AND D.
- R4: While an algorithm runs, every read returns status. Status bit 6 inverts on each new read. Once the block is idle, bit 6 stays fixed across reads. During programming, status bit 7 is the inverse of bit 7 of D.
- R5: During an erase, status bit 7 reads 0. This includes the block-erase starting read.
- R6: An erase first programs every byte of its region to 0x00 with verify, then erases the region. Writing 0x20 and then 0x20 erases the whole array, which then reads 0xFF.
- R7: Writing 0x20, then one or more writes of 0xD0 each carrying an address in a block, marks those blocks. The next read starts the erase. Only the marked blocks change. Block numbering follows the geometry given above.
- R8: If a program verify still fails after PGM_MAX pulses, the block enters the failed state. Status then reads bit 7 = 1 and bit 5 = 1. In that state every write except 0xFF is ignored.
- R9: If any byte of the region is still not 0xFF after ER_MAX erase pulses, the block enters the same failed state.
- R10: Writing 0xFF in the failed state clears bit 5 and returns the block to array-read mode.
- R11: After 0x20, a second write that is neither 0x20 nor 0xD0 returns the block to array-read mode without erasing.
- R12: Writes made while an algorithm runs have no effect on the array or on the command state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Read strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data byte |
| dout | output | 8 | Array byte or status byte |
| dout_oe | output | 1 | High while a read cycle is active |
| fault_inject | input | 2 | Bit 0 blocks program pulses, bit 1 blocks erase pulses |

## Verification
The bench sets ADDR_W = 10, which gives 1 KB with 16-byte small blocks and 64-byte large blocks. A chip erase then pre-programs every byte within a few tens of thousands of cycles. PULSE_CYC = 40 keeps each program long enough that two status reads fall inside a single operation, so toggling can be observed. PGM_MAX = 3 and ER_MAX = 4 let both retry limits run out quickly: the program limit through the AND rule of the array, and the erase limit through the erase-pulse fault input. That fault input leaves a region pre-programmed to 0x00, which makes the pre-program pass visible at the pins.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    localparam int unsigned NUM_BLOCKS = 22;

    typedef enum logic [2:0] {
        M_READ, M_PSETUP, M_ESETUP, M_BCOLLECT, M_BUSY, M_STATUS
    } mode_e;

    typedef enum logic [2:0] {
        E_IDLE, E_PRESCAN, E_PULSE, E_VERIFY, E_EPULSE, E_EAPPLY, E_EVERIFY, E_DONE
    } eng_e;

    // Block index: top eighth holds eight small blocks (14..21), the rest
    // fourteen large blocks of four times the size (0..13).
    function automatic logic [4:0] block_of(input logic [31:0] a, input int unsigned aw);
        logic [31:0] top3;
        logic [31:0] idx;
        top3 = a >> (aw - 3);
        if (top3 == 32'd7) idx = 32'd14 + ((a >> (aw - 6)) & 32'd7);
        else               idx = (a >> (aw - 4)) & 32'd15;
        return idx[4:0];
    endfunction

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              ce_s,
    output logic              oe_s,
    output logic              we_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [7:0]        din_s
);
    localparam int unsigned W = 3 + ADDR_W + 8;
    localparam logic [W-1:0] IDLE_V = {3'b111, {(ADDR_W + 8){1'b0}}};

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = {ce_n, oe_n, we_n, addr, din};
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE_V;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign {ce_s, oe_s, we_s, addr_s, din_s} = stage_q[STAGES-1];
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_host,
    output logic [7:0]        rdata_host,
    input  logic [ADDR_W-1:0] raddr_eng,
    output logic [7:0]        rdata_eng
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata_host = cell_q[raddr_host];
    assign rdata_eng  = cell_q[raddr_eng];
endmodule

// File: rtl/flash_engine.sv
module flash_engine
    import flash_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned PULSE_CYC = 8,
    parameter int unsigned PGM_MAX   = 25,
    parameter int unsigned ER_MAX    = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  is_erase,
    input  logic                  chip,
    input  logic [ADDR_W-1:0]     tgt_addr,
    input  logic [7:0]            tgt_data,
    input  logic [NUM_BLOCKS-1:0] blk_mask,
    input  logic [1:0]            inject,
    input  logic [7:0]            mem_rdata,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  failed
);
    localparam int unsigned TW      = $clog2(PULSE_CYC + 1);
    localparam int unsigned MAXC    = (PGM_MAX > ER_MAX) ? PGM_MAX : ER_MAX;
    localparam int unsigned CW      = $clog2(MAXC + 1);
    localparam logic [TW-1:0] T_INIT = TW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] C_PGM  = CW'(PGM_MAX);
    localparam logic [CW-1:0] C_ER   = CW'(ER_MAX);

    typedef struct packed {
        eng_e                  st;
        logic [ADDR_W-1:0]     cur;
        logic [7:0]            tgt;
        logic [TW-1:0]         tmr;
        logic [CW-1:0]         cnt;
        logic                  erase;
        logic                  chip;
        logic [NUM_BLOCKS-1:0] mask;
        logic                  fail;
    } eng_t;

    eng_t r_q, r_d;
    logic in_reg, last;

    assign in_reg = r_q.chip | r_q.mask[block_of(32'(r_q.cur), ADDR_W)];
    assign last   = &r_q.cur;

    always_comb begin
        r_d       = r_q;
        mem_we    = 1'b0;
        mem_wdata = 8'hFF;
        done      = 1'b0;
        unique case (r_q.st)
            E_IDLE: if (start) begin
                r_d.cur   = is_erase ? '0 : tgt_addr;
                r_d.tgt   = is_erase ? 8'h00 : tgt_data;
                r_d.erase = is_erase;
                r_d.chip  = chip;
                r_d.mask  = blk_mask;
                r_d.fail  = 1'b0;
                r_d.cnt   = CW'(1);
                r_d.tmr   = T_INIT;
                r_d.st    = is_erase ? E_PRESCAN : E_PULSE;
            end
            E_PRESCAN: begin
                if (in_reg) begin
                    r_d.tmr = T_INIT;
                    r_d.cnt = CW'(1);
                    r_d.st  = E_PULSE;
                end else if (last) begin
                    r_d.tmr = T_INIT;
                    r_d.cnt = CW'(1);
                    r_d.st  = E_EPULSE;
                end else begin
                    r_d.cur = r_q.cur + 1'b1;
                end
            end
            E_PULSE: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else begin
                    mem_we    = ~inject[0];
                    mem_wdata = mem_rdata & r_q.tgt;
                    r_d.st    = E_VERIFY;
                end
            end
            E_VERIFY: begin
                if (mem_rdata == r_q.tgt) begin
                    if (!r_q.erase) begin
                        r_d.st = E_DONE;
                    end else if (last) begin
                        r_d.tmr = T_INIT;
                        r_d.cnt = CW'(1);
                        r_d.st  = E_EPULSE;
                    end else begin
                        r_d.cur = r_q.cur + 1'b1;
                        r_d.st  = E_PRESCAN;
                    end
                end else if (r_q.cnt == C_PGM) begin
                    r_d.fail = 1'b1;
                    r_d.st   = E_DONE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    r_d.tmr = T_INIT;
                    r_d.st  = E_PULSE;
                end
            end
            E_EPULSE: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else begin
                    r_d.cur = '0;
                    r_d.st  = E_EAPPLY;
                end
            end
            E_EAPPLY: begin
                mem_we = in_reg & ~inject[1];
                if (last) begin
                    r_d.cur = '0;
                    r_d.st  = E_EVERIFY;
                end else begin
                    r_d.cur = r_q.cur + 1'b1;
                end
            end
            E_EVERIFY: begin
                if (in_reg && mem_rdata != 8'hFF) begin
                    if (r_q.cnt == C_ER) begin
                        r_d.fail = 1'b1;
                        r_d.st   = E_DONE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.tmr = T_INIT;
                        r_d.st  = E_EPULSE;
                    end
                end else if (last) begin
                    r_d.st = E_DONE;
                end else begin
                    r_d.cur = r_q.cur + 1'b1;
                end
            end
            E_DONE: begin
                done   = 1'b1;
                r_d.st = E_IDLE;
            end
            default: r_d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: E_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign mem_addr = r_q.cur;
    assign busy     = (r_q.st != E_IDLE);
    assign failed   = r_q.fail;
endmodule

// File: rtl/flash_auto_ctrl.sv
module flash_auto_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned PULSE_CYC  = 8,
    parameter int unsigned PGM_MAX    = 25,
    parameter int unsigned ER_MAX     = 1000,
    parameter logic [7:0]  OP_PSETUP  = 8'h40,
    parameter logic [7:0]  OP_ESETUP  = 8'h20,
    parameter logic [7:0]  OP_ECHIP   = 8'h20,
    parameter logic [7:0]  OP_EBLOCK  = 8'hD0,
    parameter logic [7:0]  OP_RESET   = 8'hFF,
    parameter logic [7:0]  OP_READ    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    input  logic [1:0]        fault_inject
);
    typedef struct packed {
        mode_e                 mode;
        logic                  wr_p;
        logic                  rd_p;
        logic [ADDR_W-1:0]     addr_lat;
        logic                  toggle;
        logic                  fail;
        logic [NUM_BLOCKS-1:0] mask;
        logic                  op_prog;
        logic                  prog_b7;
    } ctl_t;

    ctl_t c_q, c_d;

    logic              ce_s, oe_s, we_s;
    logic [ADDR_W-1:0] addr_s;
    logic [7:0]        din_s;
    logic              wr_act, rd_act, wr_start, wr_end, rd_start;
    logic              eng_start, eng_erase, eng_chip;
    logic              eng_busy, eng_done, eng_fail;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata, host_rdata, status;

    flash_bus_sync #(.ADDR_W(ADDR_W), .STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
        .addr_s(addr_s), .din_s(din_s)
    );

    flash_array #(.ADDR_W(ADDR_W)) i_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr_host(addr_s), .rdata_host(host_rdata),
        .raddr_eng(mem_addr), .rdata_eng(mem_rdata)
    );

    flash_engine #(
        .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .PGM_MAX(PGM_MAX), .ER_MAX(ER_MAX)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .is_erase(eng_erase),
        .chip(eng_chip), .tgt_addr(c_q.addr_lat), .tgt_data(din_s),
        .blk_mask(c_q.mask), .inject(fault_inject), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(eng_busy), .done(eng_done), .failed(eng_fail)
    );

    assign wr_act   = ~ce_s & ~we_s;
    assign rd_act   = ~ce_s & ~oe_s & we_s;
    assign wr_start = wr_act & ~c_q.wr_p;
    assign wr_end   = ~wr_act & c_q.wr_p;
    assign rd_start = rd_act & ~c_q.rd_p;

    always_comb begin
        c_d       = c_q;
        eng_start = 1'b0;
        eng_erase = 1'b0;
        eng_chip  = 1'b0;
        c_d.wr_p  = wr_act;
        c_d.rd_p  = rd_act;
        if (wr_start) c_d.addr_lat = addr_s;
        unique case (c_q.mode)
            M_READ: if (wr_end) begin
                if (din_s == OP_PSETUP) begin
                    c_d.mode = M_PSETUP;
                end else if (din_s == OP_ESETUP) begin
                    c_d.mode = M_ESETUP;
                    c_d.mask = '0;
                end else if (din_s == OP_RESET || din_s == OP_READ) begin
                    c_d.mode = M_READ;
                end
            end
            M_PSETUP: if (wr_end) begin
                eng_start   = 1'b1;
                c_d.mode    = M_BUSY;
                c_d.op_prog = 1'b1;
                c_d.prog_b7 = din_s[7];
            end
            M_ESETUP: if (wr_end) begin
                if (din_s == OP_ECHIP) begin
                    eng_start   = 1'b1;
                    eng_erase   = 1'b1;
                    eng_chip    = 1'b1;
                    c_d.mode    = M_BUSY;
                    c_d.op_prog = 1'b0;
                end else if (din_s == OP_EBLOCK) begin
                    c_d.mask[block_of(32'(c_q.addr_lat), ADDR_W)] = 1'b1;
                    c_d.mode = M_BCOLLECT;
                end else begin
                    c_d.mode = M_READ;
                end
            end
            M_BCOLLECT: begin
                if (wr_end) begin
                    if (din_s == OP_EBLOCK)
                        c_d.mask[block_of(32'(c_q.addr_lat), ADDR_W)] = 1'b1;
                    else
                        c_d.mode = M_READ;
                end else if (rd_start) begin
                    eng_start   = 1'b1;
                    eng_erase   = 1'b1;
                    c_d.mode    = M_BUSY;
                    c_d.op_prog = 1'b0;
                end
            end
            M_BUSY: begin
                if (rd_start) c_d.toggle = ~c_q.toggle;
                if (eng_done) begin
                    c_d.fail = eng_fail;
                    c_d.mode = eng_fail ? M_STATUS : M_READ;
                end
            end
            M_STATUS: if (wr_end && din_s == OP_RESET) begin
                c_d.fail = 1'b0;
                c_d.mode = M_READ;
            end
            default: c_d.mode = M_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{mode: M_READ, default: '0};
        else        c_q <= c_d;
    end

    always_comb begin
        if (c_q.mode == M_BUSY)
            status = {c_q.op_prog & ~c_q.prog_b7, c_q.toggle, 1'b0, 5'b0};
        else
            status = {1'b1, c_q.toggle, c_q.fail, 5'b0};
    end

    assign dout_oe = rd_act;
    assign dout    = (c_q.mode == M_BUSY || c_q.mode == M_STATUS) ? status : host_rdata;
endmodule

// File: rtl/flash_auto_ctrl_chk.sv
module flash_auto_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_busy,
    input logic       eng_done,
    input logic       eng_busy,
    input logic       eng_start,
    input logic       toggle,
    input logic       mem_we,
    input logic       fail_q,
    input logic       dout_oe,
    input logic [7:0] dout
);
    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy && !eng_done) |=> mode_busy);

    assert_start_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    assert_toggle_frozen_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_busy |=> $stable(toggle));

    assert_array_write_by_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> eng_busy);

    assert_fail_from_engine_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> $past(eng_done));

    assert_fail_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && fail_q) |-> dout[5]);
endmodule

bind flash_auto_ctrl flash_auto_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n),
    .mode_busy(c_q.mode == flash_ctrl_pkg::M_BUSY),
    .eng_done(eng_done), .eng_busy(eng_busy), .eng_start(eng_start),
    .toggle(c_q.toggle), .mem_we(mem_we), .fail_q(c_q.fail),
    .dout_oe(dout_oe), .dout(dout)
);

// File: tb/test_flash_auto_ctrl.sv
module test_flash_auto_ctrl;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [1:0]    inj = 2'b00;
    logic [7:0]    dout;
    logic          dout_oe;

    always #5 clk = ~clk;

    flash_auto_ctrl #(.ADDR_W(AW), .PULSE_CYC(40), .PGM_MAX(3), .ER_MAX(4)) i_flash_auto_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .fault_inject(inj)
    );

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_cmp = 0, n_bad = 0, oe_cnt = 0;
    logic [7:0] seen = 8'h00;
    bit         finished = 0;

    // Monitor: samples once the read has settled, compares against the queue head.
    always @(negedge clk) begin
        if (dout_oe) begin
            oe_cnt++;
            if (oe_cnt == 2) begin
                seen = dout;
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    n_cmp++;
                    if (((dout ^ e.exp) & e.mask) != 8'h00) begin
                        n_bad++;
                        $display("FAIL %s: got %02h expected %02h (mask %02h)",
                                 e.tag, dout, e.exp, e.mask);
                    end
                end
            end
        end else begin
            oe_cnt = 0;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        ce_n = 1'b0; addr = a; tick(1);
        we_n = 1'b0; tick(3);
        din = d; tick(1);
        we_n = 1'b1; tick(3);
        ce_n = 1'b1; din = 8'h00; tick(2);
    endtask

    // Chip-select controlled write; address and data lines carry junk outside the latch points.
    task automatic wr_ce(logic [AW-1:0] a, logic [7:0] d);
        addr = a; we_n = 1'b0; tick(1);
        ce_n = 1'b0; tick(3);
        addr = ~a; din = d; tick(1);
        ce_n = 1'b1; tick(2);
        din = ~d; tick(2);
        we_n = 1'b1; din = 8'h00; tick(2);
    endtask

    task automatic bus_read(logic [AW-1:0] a);
        ce_n = 1'b0; addr = a; oe_n = 1'b0; tick(4);
        oe_n = 1'b1; ce_n = 1'b1; tick(2);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [7:0] e, logic [7:0] m, string tag);
        exp_t x;
        x.exp = e; x.mask = m; x.tag = tag;
        sb.push_back(x);
        bus_read(a);
    endtask

    task automatic peek(logic [AW-1:0] a, output logic [7:0] v);
        bus_read(a);
        v = seen;
    endtask

    task automatic wait_idle(logic [AW-1:0] a);
        logic [7:0] v1, v2;
        for (int i = 0; i < 20000; i++) begin
            peek(a, v1);
            peek(a, v2);
            if (v1[6] == v2[6]) break;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R1: erased array, read mode
        rd(10'h000, 8'hFF, 8'hFF, "R1 reset low");
        rd(10'h3FF, 8'hFF, 8'hFF, "R1 reset high");

        // R3: program by write strobe
        wr(10'h000, 8'h40); wr(10'h005, 8'h5A);
        wait_idle(10'h005);
        rd(10'h005, 8'h5A, 8'hFF, "R3 program");

        // R4: status while programming, data bit7 = 1 -> poll bit7 = 0, toggling bit6
        wr(10'h000, 8'h40); wr(10'h006, 8'h81);
        peek(10'h006, v);
        rd(10'h006, {1'b0, ~v[6], 6'b0}, 8'hC0, "R4 poll/toggle");
        wait_idle(10'h006);
        rd(10'h006, 8'h81, 8'hFF, "R3 program data");

        // R2: chip-select controlled write with junk outside latch points
        wr_ce(10'h000, 8'h40); wr_ce(10'h010, 8'h3C);
        wait_idle(10'h010);
        rd(10'h010, 8'h3C, 8'hFF, "R2 ce controlled");

        // R8: 0x5A AND 0xA5 never verifies -> failed state
        wr(10'h000, 8'h40); wr(10'h005, 8'hA5);
        wait_idle(10'h005);
        rd(10'h005, 8'hA0, 8'hA0, "R8 fail status");
        peek(10'h005, v);
        rd(10'h005, v, 8'h40, "R4 toggle frozen");
        wr(10'h000, 8'h40);
        rd(10'h005, 8'h20, 8'h20, "R8 non-reset write ignored");

        // R10: reset command leaves failed state
        wr(10'h000, 8'hFF);
        rd(10'h005, 8'h00, 8'hFF, "R10 reset to read");

        // R11: unexpected second write aborts erase setup
        wr(10'h000, 8'h20); wr(10'h005, 8'h77);
        rd(10'h006, 8'h81, 8'hFF, "R11 aborted setup");

        // R7: multi-block erase (block 14 and block 0)
        wr(10'h000, 8'h40); wr(10'h040, 8'h99); wait_idle(10'h040);
        wr(10'h000, 8'h40); wr(10'h385, 8'h22); wait_idle(10'h385);
        wr(10'h000, 8'h40); wr(10'h390, 8'h11); wait_idle(10'h390);
        wr(10'h000, 8'h20); wr(10'h380, 8'hD0); wr(10'h000, 8'hD0);
        rd(10'h3FF, 8'h00, 8'h80, "R5 erase poll bit");
        // R12: writes during the erase are ignored
        wr(10'h3C0, 8'h40); wr(10'h3C0, 8'h00);
        wait_idle(10'h3C0);
        rd(10'h3C0, 8'hFF, 8'hFF, "R12 busy write ignored");
        rd(10'h005, 8'hFF, 8'hFF, "R7 block0 erased");
        rd(10'h010, 8'hFF, 8'hFF, "R7 block0 erased b");
        rd(10'h385, 8'hFF, 8'hFF, "R7 block14 erased");
        rd(10'h390, 8'h11, 8'hFF, "R7 block15 kept");
        rd(10'h040, 8'h99, 8'hFF, "R7 block1 kept");

        // R9/R6: erase pulses blocked -> region left pre-programmed, fail flag
        inj = 2'b10;
        wr(10'h000, 8'h20); wr(10'h040, 8'hD0);
        rd(10'h040, 8'h00, 8'h80, "R5 erase poll bit b");
        wait_idle(10'h040);
        rd(10'h040, 8'hA0, 8'hA0, "R9 erase fail status");
        wr(10'h000, 8'hFF);
        inj = 2'b00;
        rd(10'h040, 8'h00, 8'hFF, "R6 preprogram first");
        rd(10'h07F, 8'h00, 8'hFF, "R6 preprogram last");
        rd(10'h080, 8'hFF, 8'hFF, "R7 neighbour kept");

        // R6: chip erase
        wr(10'h000, 8'h20); wr(10'h000, 8'h20);
        wait_idle(10'h000);
        rd(10'h040, 8'hFF, 8'hFF, "R6 chip erase a");
        rd(10'h390, 8'hFF, 8'hFF, "R6 chip erase b");
        rd(10'h006, 8'hFF, 8'hFF, "R6 chip erase c");

        tick(4);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule